// File: doc/BRIEF.md
# Slicer Threshold Hysteresis Comparator

This block turns a digitized receive-line level into a binary slicer decision. Software or an upstream controller programs a 6-bit threshold code and a 2-bit hysteresis select. The block derives two thresholds from them: a lower one equal to the code, and an upper one equal to the code plus a fixed offset chosen by the select. Each sample arrives as an unsigned code on the same scale as the threshold, and a strobe marks it as valid.

The output rises only when a strobed level lies strictly above the upper threshold. It falls only when a strobed level lies strictly below the lower threshold. For any level between the two, the output keeps its state. The output is registered. A one-cycle change pulse accompanies every transition, so that a later interrupt mask-and-latch stage can use it as an event source.

Top module: `slicer_hyst_cmp`

## Requirements
- R1: A synchronous active-high reset drives `slice_out` low and `slice_chg` low on the clock edge that samples it.
- R2: The lower threshold equals `thr_code`. A strobed level strictly below it drives the output low. A level equal to it leaves the output unchanged.
- R3: With `hys_sel` = 2'b00 the upper threshold equals `thr_code`. A strobed level of `thr_code`+1 raises the output, and a level equal to `thr_code` does not.
- R4: With `hys_sel` = 2'b01 the upper threshold is `thr_code`+5. The output rises at `thr_code`+6 but not at `thr_code`+5.
- R5: With `hys_sel` = 2'b10 the upper threshold is `thr_code`+10. The output rises at `thr_code`+11 but not at `thr_code`+10.
- R6: With `hys_sel` = 2'b11 the upper threshold is `thr_code`+32. The output rises at `thr_code`+33 but not at `thr_code`+32.
- R7: The upper threshold is formed one bit wider than the code, so the sum cannot wrap. With `thr_code`=60 and `hys_sel`=2'b11, even the largest level (63) leaves the output low.
- R8: A strobed level with lower <= level <= upper holds the output in either state.
- R9: While `smp_valid` is low, `smp_level` has no effect on `slice_out` or `slice_chg`.
- R10: A change of `thr_code` or `hys_sel` never forces the output. The new values take effect at the next strobed sample.
- R11: `slice_out` and `slice_chg` update on the clock edge that samples the strobe. `slice_chg` is high for exactly the one cycle after each transition, rising or falling, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_code | input | 6 | Programmed threshold code (lower threshold) |
| hys_sel | input | 2 | Hysteresis select: 00 none, 01 +5, 10 +10, 11 +32 |
| smp_valid | input | 1 | Strobe qualifying `smp_level` |
| smp_level | input | 6 | Digitized line level, same scale as `thr_code` |
| slice_out | output | 1 | Registered slicer decision |
| slice_chg | output | 1 | One-cycle pulse on each `slice_out` transition |

## Verification
Each result lands on the first rising edge after the strobe is presented. Both `slice_out` and `slice_chg` change at that edge, with no extra pipeline stage. The bench drives inputs on the falling edge, lowers the strobe on the next falling edge, and samples both outputs at that falling edge, half a cycle after the result was registered. One more falling edge later it checks that the pulse has dropped. The threshold-change and no-strobe cases check the outputs over several idle cycles, because those inputs must have no effect until a strobe comes.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

    typedef enum logic [1:0] {
        HYS_NONE  = 2'b00,
        HYS_SMALL = 2'b01,
        HYS_MID   = 2'b10,
        HYS_WIDE  = 2'b11
    } hys_sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_RISE = 2'b01,
        ACT_FALL = 2'b10
    } slice_act_e;

    localparam int unsigned OFS_NONE  = 0;
    localparam int unsigned OFS_SMALL = 5;
    localparam int unsigned OFS_MID   = 10;
    localparam int unsigned OFS_WIDE  = 32;

    // Non-uniform offset added to the code for the upper threshold
    function automatic int unsigned hys_offset(input hys_sel_e sel);
        case (sel)
            HYS_SMALL: return OFS_SMALL;
            HYS_MID:   return OFS_MID;
            HYS_WIDE:  return OFS_WIDE;
            default:   return OFS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/slc_thresh.sv
module slc_thresh
    import slicer_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int TH_W   = CODE_W + 1
) (
    input  logic [CODE_W-1:0] thr_code,
    input  logic [1:0]        hys_sel,
    output logic [TH_W-1:0]   th_lo,
    output logic [TH_W-1:0]   th_hi
);
    hys_sel_e sel_e;

    always_comb begin
        sel_e = hys_sel_e'(hys_sel);
        th_lo = TH_W'(thr_code);
        th_hi = TH_W'(thr_code) + TH_W'(hys_offset(sel_e));
    end
endmodule

// File: rtl/slc_decide.sv
module slc_decide
    import slicer_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter int TH_W  = 7
) (
    input  logic             smp_valid,
    input  logic [LVL_W-1:0] smp_level,
    input  logic [TH_W-1:0]  th_lo,
    input  logic [TH_W-1:0]  th_hi,
    output slice_act_e       act
);
    localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;

    logic [CMP_W-1:0] lvl_x, lo_x, hi_x;
    logic             above, below;

    always_comb begin
        lvl_x = CMP_W'(smp_level);
        lo_x  = CMP_W'(th_lo);
        hi_x  = CMP_W'(th_hi);
        above = lvl_x > hi_x;
        below = lvl_x < lo_x;
        if (!smp_valid)  act = ACT_HOLD;
        else if (above)  act = ACT_RISE;
        else if (below)  act = ACT_FALL;
        else             act = ACT_HOLD;
    end
endmodule

// File: rtl/slc_state.sv
module slc_state
    import slicer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slice_act_e act,
    output logic       slice_out,
    output logic       slice_chg
);
    logic nxt_out;

    always_comb begin
        case (act)
            ACT_RISE: nxt_out = 1'b1;
            ACT_FALL: nxt_out = 1'b0;
            default:  nxt_out = slice_out;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slice_out <= 1'b0;
            slice_chg <= 1'b0;
        end else begin
            slice_out <= nxt_out;
            slice_chg <= nxt_out ^ slice_out;
        end
    end
endmodule

// File: rtl/slicer_hyst_cmp.sv
module slicer_hyst_cmp
    import slicer_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int LVL_W  = CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] thr_code,
    input  logic [1:0]        hys_sel,
    input  logic              smp_valid,
    input  logic [LVL_W-1:0]  smp_level,
    output logic              slice_out,
    output logic              slice_chg
);
    // One extra bit keeps code + largest offset from wrapping
    localparam int TH_W = CODE_W + 1;

    logic [TH_W-1:0] th_lo, th_hi;
    slice_act_e      act;

    slc_thresh #(.CODE_W(CODE_W), .TH_W(TH_W)) thresh_i (
        .thr_code (thr_code),
        .hys_sel  (hys_sel),
        .th_lo    (th_lo),
        .th_hi    (th_hi)
    );

    slc_decide #(.LVL_W(LVL_W), .TH_W(TH_W)) decide_i (
        .smp_valid (smp_valid),
        .smp_level (smp_level),
        .th_lo     (th_lo),
        .th_hi     (th_hi),
        .act       (act)
    );

    slc_state state_i (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .slice_out (slice_out),
        .slice_chg (slice_chg)
    );
endmodule

// File: rtl/slicer_hyst_cmp_chk.sv
module slicer_hyst_cmp_chk #(
    parameter int CODE_W = 6,
    parameter int LVL_W  = CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] thr_code,
    input logic [1:0]        hys_sel,
    input logic              smp_valid,
    input logic [LVL_W-1:0]  smp_level,
    input logic              slice_out,
    input logic              slice_chg
);
    localparam int W = ((LVL_W > CODE_W) ? LVL_W : CODE_W) + 2;

    logic [W-1:0] chk_hi;
    always_comb begin
        case (hys_sel)
            2'b01:   chk_hi = W'(thr_code) + W'(5);
            2'b10:   chk_hi = W'(thr_code) + W'(10);
            2'b11:   chk_hi = W'(thr_code) + W'(32);
            default: chk_hi = W'(thr_code);
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!slice_out && !slice_chg));

    assert_rise_above_upper_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_out) |-> ($past(smp_valid) && (W'($past(smp_level)) > $past(chk_hi))));

    assert_fall_below_lower_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(slice_out) && !$past(rst)) |->
            ($past(smp_valid) && ($past(smp_level) < LVL_W'($past(thr_code)))));

    assert_no_strobe_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(slice_out));

    assert_pulse_on_toggle_R11: assert property (@(posedge clk) disable iff (rst)
        slice_chg |-> (slice_out != $past(slice_out)));

    assert_toggle_has_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        ((slice_out != $past(slice_out)) && !$past(rst)) |-> slice_chg);
endmodule

bind slicer_hyst_cmp slicer_hyst_cmp_chk #(.CODE_W(CODE_W), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .thr_code  (thr_code),
    .hys_sel   (hys_sel),
    .smp_valid (smp_valid),
    .smp_level (smp_level),
    .slice_out (slice_out),
    .slice_chg (slice_chg)
);

// File: tb/slicer_hyst_cmp_tb_top.sv
`timescale 1ns/1ps
module slicer_hyst_cmp_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] thr_code = '0;
    logic [1:0] hys_sel = '0;
    logic       smp_valid = 1'b0;
    logic [5:0] smp_level = '0;
    logic       slice_out, slice_chg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    slicer_hyst_cmp dut_i (
        .clk(clk), .rst(rst), .thr_code(thr_code), .hys_sel(hys_sel),
        .smp_valid(smp_valid), .smp_level(smp_level),
        .slice_out(slice_out), .slice_chg(slice_chg)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // Present one strobed level; check output and pulse, then pulse drop
    task automatic strobe(input logic [5:0] lvl, input logic exp, input string what);
        logic prev;
        prev = slice_out;
        smp_level = lvl;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        check(slice_out, exp, {what, " out"});
        check(slice_chg, exp ^ prev, {what, " chg R11"});
        @(negedge clk);
        check(slice_chg, 1'b0, {what, " chg drop R11"});
    endtask

    task automatic set_cfg(input logic [5:0] c, input logic [1:0] h);
        thr_code = c;
        hys_sel  = h;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(slice_out, 1'b0, "R1 reset out");
        check(slice_chg, 1'b0, "R1 reset chg");
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_none;
        set_cfg(6'd20, 2'b00);
        strobe(6'd20, 1'b0, "R3 equal no rise");
        strobe(6'd21, 1'b1, "R3 rise above");
        strobe(6'd20, 1'b1, "R2 equal holds high");
        strobe(6'd19, 1'b0, "R2 fall below");
    endtask

    task automatic t_small;
        set_cfg(6'd20, 2'b01);
        strobe(6'd25, 1'b0, "R4 at upper");
        strobe(6'd26, 1'b1, "R4 rise");
        strobe(6'd22, 1'b1, "R8 band holds high");
        strobe(6'd20, 1'b1, "R8 lower edge holds");
        strobe(6'd19, 1'b0, "R2 fall small");
        strobe(6'd23, 1'b0, "R8 band holds low");
    endtask

    task automatic t_mid;
        set_cfg(6'd20, 2'b10);
        strobe(6'd30, 1'b0, "R5 at upper");
        strobe(6'd31, 1'b1, "R5 rise");
        strobe(6'd19, 1'b0, "R5 fall");
    endtask

    task automatic t_wide;
        set_cfg(6'd20, 2'b11);
        strobe(6'd52, 1'b0, "R6 at upper");
        strobe(6'd53, 1'b1, "R6 rise");
        strobe(6'd40, 1'b1, "R8 wide band holds");
        strobe(6'd19, 1'b0, "R6 fall");
    endtask

    task automatic t_top;
        set_cfg(6'd60, 2'b11);
        strobe(6'd63, 1'b0, "R7 no wrap max level");
        set_cfg(6'd62, 2'b00);
        strobe(6'd63, 1'b1, "R7 rise near top");
        set_cfg(6'd60, 2'b11);
        strobe(6'd61, 1'b1, "R7 holds near top");
        strobe(6'd59, 1'b0, "R7 fall near top");
    endtask

    task automatic t_nostrobe;
        set_cfg(6'd10, 2'b00);
        smp_level = 6'd63;
        smp_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(slice_out, 1'b0, "R9 no strobe out");
            check(slice_chg, 1'b0, "R9 no strobe chg");
        end
        strobe(6'd63, 1'b1, "R9 strobe rises");
    endtask

    task automatic t_cfg_change;
        set_cfg(6'd50, 2'b00);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(slice_out, 1'b1, "R10 cfg change keeps out");
            check(slice_chg, 1'b0, "R10 cfg change no pulse");
        end
        strobe(6'd45, 1'b0, "R10 new code applies");
    endtask

    task automatic t_reset_mid;
        set_cfg(6'd5, 2'b00);
        strobe(6'd30, 1'b1, "R1 setup high");
        rst = 1'b1;
        @(negedge clk);
        check(slice_out, 1'b0, "R1 midrun reset out");
        check(slice_chg, 1'b0, "R1 midrun reset chg");
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_none();
        t_small();
        t_mid();
        t_wide();
        t_top();
        t_nostrobe();
        t_cfg_change();
        t_reset_mid();
        finish_run();
    end
endmodule